// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a two-level programmable logic fabric. It takes `N_IN` input bits and produces `M_OUT` output bits. Each output is the OR of a chosen set of product terms. Each product term is the AND of a chosen set of input literals, where a literal is either an input or its complement. The outputs follow the inputs combinationally. The connections in both planes are held in registers. A synchronous write port loads them one AND-plane row or one OR-plane column per clock, and an active-low synchronous reset clears them.

A build-time parameter selects one of three personalities:

- **Read-only table.** The AND plane is a fixed decoder that produces all 2^N_IN minterms. Only the OR plane is written, so the array holds a full truth table.
- **Fully programmable array.** Both planes are written. There are `P_TERMS` terms, and any term may feed any number of outputs.
- **Fixed-OR array.** The AND plane is written. Each output owns a private, contiguous group of terms. The size of each group comes from a parameter, so outputs can have different term budgets and no term is shared.

Top module: `sop_logic_array`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears both planes. Afterwards, every output is 0 for every input value until new configuration is written.
- R2: In each AND-plane row, bit 2i selects the true literal of input i and bit 2i+1 selects its complement. A term is 1 only when every selected literal is 1.
- R3: A term row with no literal selected evaluates to 1. A row that selects both literals of the same input evaluates to 0.
- R4: Each output equals the OR of the terms whose bit is set in that output's OR-plane column. A column with no bit set drives 0.
- R5: In the fully programmable personality, one term may be connected to several outputs at once, and it drives all of them.
- R6: In the read-only personality, term j is 1 exactly when the input value equals j. OR-column bit j is therefore the output's value for input j. Writes addressed to the AND plane have no effect.
- R7: In the fixed-OR personality, output k owns the contiguous terms that follow the groups of outputs 0..k-1. The group size is byte k of PAL_SIZES; the default is 3, 2, 2, 1 for outputs 0 to 3. OR-column bits for terms an output does not own are ignored.
- R8: In the fixed-OR personality, an output can never realise more product terms than it owns. With the defaults, output 3 takes only term 7, even when its column write sets bits 6 and 7.
- R9: Configuration address: the top bit selects the plane (0 = AND row, 1 = OR column) and the low bits give the row or column index. A write whose index is outside the plane is ignored. A plane holds its contents in every cycle with cfg_we low.
- R10: Outputs respond to input changes within the same cycle, with no clock edge. A write becomes visible on the outputs right after the clock edge that samples it.
- R11: With two inputs and two outputs, out0 = i1·i0 + i1·i0' and out1 = i1·i0 + i1'·i0' are reproduced in both the read-only and the programmable personality, with i1·i0 a single shared term in the programmable one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset; clears both planes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Plane select (top bit) and row/column index |
| cfg_data | input | DW | Row literal bits or column term bits |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | M_OUT | Combinational logic outputs |

## Verification
The embedded properties assume three things. Reset is held low for at least one clock edge before any check. cfg_addr and cfg_data are known whenever cfg_we is high. In the fixed-OR build, the PAL_SIZES groups sum to no more than the term count. The bench keeps to these assumptions: it holds reset for three cycles, drives every configuration field from a defined value and always uses the default group sizes. It also changes inputs and the write strobe only at falling edges, so the hold-stability property sees settled values. The random phase draws addresses across the whole address space, including indices beyond the planes, so the ignore rules are exercised alongside normal writes.

// File: rtl/sop_pkg.sv
// Package: shared types and helpers for the sum-of-products array.
// Assumes nothing beyond elaboration-time constant arguments.
package sop_pkg;

    // Build-time personality of the array
    typedef enum logic [1:0] {
        SOP_ROM = 2'd0,  // fixed full decoder, programmable OR plane
        SOP_PLA = 2'd1,  // both planes programmable, terms shareable
        SOP_PAL = 2'd2   // programmable AND plane, fixed private term groups
    } sop_mode_e;

    // Number of product terms the fabric carries for a personality
    function automatic int term_count(input sop_mode_e mode, input int n_in, input int p_terms);
        return (mode == SOP_ROM) ? (1 << n_in) : p_terms;
    endfunction

    // Larger of two integers, for port width derivation
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sop_cfg_decode.sv
// Module: sop_cfg_decode
// Turns one configuration write into at most one row strobe and one column
// strobe. The top address bit picks the plane; the low bits index it.
// Indices beyond a plane match no strobe, so such writes are dropped.
// Assumes: addr is known while we is high.
module sop_cfg_decode
    import sop_pkg::*;
#(
    parameter sop_mode_e MODE  = SOP_PLA,
    parameter int        NT    = 8,
    parameter int        M_OUT = 4,
    parameter int        IW    = 3,
    localparam int       AW    = IW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    output logic [NT-1:0]     row_we,
    output logic [M_OUT-1:0]  col_we
);

    logic          sel_or;
    logic [IW-1:0] idx;

    // Split the address into plane select and index
    always_comb begin
        sel_or = addr[AW-1];
        idx    = addr[IW-1:0];
    end

    genvar t;
    genvar k;
    generate
        for (t = 0; t < NT; t++) begin : g_row
            if (MODE == SOP_ROM) begin : g_fixed
                // The decoder plane has no storage, so rows never take a strobe
                assign row_we[t] = 1'b0;
            end else begin : g_prog
                // Row strobe when the AND plane is addressed at this index
                assign row_we[t] = we && !sel_or && (idx == IW'(t));
            end
        end
        for (k = 0; k < M_OUT; k++) begin : g_col
            // Column strobe when the OR plane is addressed at this index
            assign col_we[k] = we && sel_or && (idx == IW'(k));
        end
    endgenerate

    // R9: a single write never reaches two storage targets
    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_we, col_we}));

    // R9: without a write strobe no target is enabled
    a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !we |-> ({row_we, col_we} == '0));

endmodule

// File: rtl/sop_and_plane.sv
// Module: sop_and_plane
// Produces the product-term vector. In the read-only personality it is a
// fixed decoder of all minterms. Otherwise each term is stored as a row of
// literal-select pairs (bit 2i true input i, bit 2i+1 complement).
// Assumes: row_we is at most one-hot; rows are cleared by synchronous reset.
module sop_and_plane
    import sop_pkg::*;
#(
    parameter sop_mode_e MODE = SOP_PLA,
    parameter int        N_IN = 4,
    parameter int        NT   = 8,
    localparam int       RW   = 2 * N_IN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NT-1:0]   row_we,
    input  logic [RW-1:0]   row_data,
    input  logic [N_IN-1:0] in_vec,
    output logic [NT-1:0]   terms
);

    genvar t;
    generate
        if (MODE == SOP_ROM) begin : g_decoder
            for (t = 0; t < NT; t++) begin : g_min
                // Minterm t is high exactly when the inputs encode t
                assign terms[t] = (in_vec == N_IN'(t));
            end

            // R6: exactly one minterm is active for any input value
            a_r6_one_minterm: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(terms));

            logic unused_rows;
            // Row port is inert in this personality
            assign unused_rows = ^{row_we, row_data};
        end else begin : g_rows
            logic [NT-1:0][RW-1:0] rows;

            // Load or clear literal-select rows
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    rows <= '0;
                end else begin
                    for (int r = 0; r < NT; r++) begin
                        if (row_we[r]) rows[r] <= row_data;
                    end
                end
            end

            for (t = 0; t < NT; t++) begin : g_term
                logic hit;
                // AND of every selected literal; empty row yields 1
                always_comb begin
                    hit = 1'b1;
                    for (int i = 0; i < N_IN; i++) begin
                        if (rows[t][2*i]   && !in_vec[i]) hit = 1'b0;
                        if (rows[t][2*i+1] &&  in_vec[i]) hit = 1'b0;
                    end
                end
                assign terms[t] = hit;
            end

            // R9: rows hold their contents when no row is strobed
            a_r9_rows_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (row_we == '0) |=> $stable(rows));

            // R3: a row selecting no literal always yields an active term
            a_r3_empty_row_true: assert property (@(posedge clk) disable iff (!rst_n)
                (rows[0] == '0) |-> terms[0]);
        end
    endgenerate

endmodule

// File: rtl/sop_or_plane.sv
// Module: sop_or_plane
// Holds one term-select column per output and ORs the selected terms.
// In the fixed-OR personality each column is masked on write to the group
// of terms its output owns, so no term can feed two outputs.
// Assumes: col_we is at most one-hot; PAL_SIZES groups fit inside NT.
module sop_or_plane
    import sop_pkg::*;
#(
    parameter sop_mode_e   MODE      = SOP_PLA,
    parameter int          M_OUT     = 4,
    parameter int          NT        = 8,
    parameter logic [63:0] PAL_SIZES = 64'h0000_0000_0102_0203
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [M_OUT-1:0] col_we,
    input  logic [NT-1:0]    col_data,
    input  logic [NT-1:0]    terms,
    output logic [M_OUT-1:0] out_vec
);

    // Terms owned by output k: all terms unless groups are fixed
    function automatic logic [NT-1:0] own_mask(input int k);
        int            first;
        int            size;
        logic [NT-1:0] m;
        first = 0;
        m     = '0;
        if (MODE != SOP_PAL) return '1;
        for (int j = 0; j < k; j++) first += int'(PAL_SIZES[8*j +: 8]);
        size = int'(PAL_SIZES[8*k +: 8]);
        for (int t = 0; t < NT; t++) m[t] = (t >= first) && (t < first + size);
        return m;
    endfunction

    logic [M_OUT-1:0][NT-1:0] cols;

    genvar k;
    genvar t;
    generate
        for (k = 0; k < M_OUT; k++) begin : g_col
            localparam logic [NT-1:0] MASK = own_mask(k);

            // Load a masked column or clear it on reset
            always_ff @(posedge clk) begin
                if (!rst_n)         cols[k] <= '0;
                else if (col_we[k]) cols[k] <= col_data & MASK;
            end

            // Sum of the selected product terms
            assign out_vec[k] = |(cols[k] & terms);

            // R4: an empty column can never raise its output
            a_r4_empty_col_low: assert property (@(posedge clk) disable iff (!rst_n)
                (cols[k] == '0) |-> !out_vec[k]);

            // R7: a column never holds a term outside its group
            a_r7_col_in_group: assert property (@(posedge clk) disable iff (!rst_n)
                (cols[k] & ~MASK) == '0);
        end

        if (MODE == SOP_PAL) begin : g_private
            for (t = 0; t < NT; t++) begin : g_use
                logic [M_OUT-1:0] users;
                // Gather which outputs connect term t
                always_comb begin
                    for (int j = 0; j < M_OUT; j++) users[j] = cols[j][t];
                end

                // R7: no term is connected to more than one output
                a_r7_no_shared_term: assert property (@(posedge clk) disable iff (!rst_n)
                    $onehot0(users));
            end
        end
    endgenerate

    // R9: columns hold their contents when none is strobed
    a_r9_cols_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (col_we == '0) |=> $stable(cols));

endmodule

// File: rtl/sop_logic_array.sv
// Module: sop_logic_array
// Top of the configurable two-level logic array. Wires the configuration
// decoder, the AND plane and the OR plane together. Evaluation is purely
// combinational from in_vec; only configuration is registered.
// Assumes: rst_n is held low for at least one clock before use; in the
// fixed-OR build M_OUT <= 8 and PAL_SIZES bytes sum to at most P_TERMS.
module sop_logic_array
    import sop_pkg::*;
#(
    parameter sop_mode_e   MODE      = SOP_PLA,
    parameter int          N_IN      = 4,
    parameter int          M_OUT     = 4,
    parameter int          P_TERMS   = 8,
    parameter logic [63:0] PAL_SIZES = 64'h0000_0000_0102_0203,
    localparam int         NT        = term_count(MODE, N_IN, P_TERMS),
    localparam int         IW        = $clog2(imax(imax(NT, M_OUT), 2)),
    localparam int         AW        = IW + 1,
    localparam int         DW        = imax(2 * N_IN, NT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_data,
    input  logic [N_IN-1:0]  in_vec,
    output logic [M_OUT-1:0] out_vec
);

    logic [NT-1:0]    row_we;
    logic [M_OUT-1:0] col_we;
    logic [NT-1:0]    terms;

    sop_cfg_decode #(
        .MODE  (MODE),
        .NT    (NT),
        .M_OUT (M_OUT),
        .IW    (IW)
    ) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .row_we (row_we),
        .col_we (col_we)
    );

    sop_and_plane #(
        .MODE (MODE),
        .N_IN (N_IN),
        .NT   (NT)
    ) u_and (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_we   (row_we),
        .row_data (cfg_data[2*N_IN-1:0]),
        .in_vec   (in_vec),
        .terms    (terms)
    );

    sop_or_plane #(
        .MODE      (MODE),
        .M_OUT     (M_OUT),
        .NT        (NT),
        .PAL_SIZES (PAL_SIZES)
    ) u_or (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_we   (col_we),
        .col_data (cfg_data[NT-1:0]),
        .terms    (terms),
        .out_vec  (out_vec)
    );

    // R1: the first cycle after reset shows all outputs low
    a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (out_vec == '0));

    // R10: without a write and with steady inputs the outputs do not move
    a_r10_steady_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!cfg_we) && $stable(in_vec)) |-> $stable(out_vec));

endmodule

// File: tb/tb_sop_logic_array.sv
// Bench: five builds of the array (programmable, read-only and fixed-OR at
// 4x4, plus two 2x2 builds), directed corners and seeded random traffic.
module tb_sop_logic_array;
    import sop_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] vin = '0;

    // programmable 4x4, 8 terms: AW=4 DW=8
    logic p_we = 1'b0; logic [3:0] p_addr = '0; logic [7:0]  p_data = '0; logic [3:0] p_out;
    // read-only 4x4, 16 minterms: AW=5 DW=16
    logic r_we = 1'b0; logic [4:0] r_addr = '0; logic [15:0] r_data = '0; logic [3:0] r_out;
    // fixed-OR 4x4, 8 terms: AW=4 DW=8
    logic f_we = 1'b0; logic [3:0] f_addr = '0; logic [7:0]  f_data = '0; logic [3:0] f_out;
    // programmable 2x2, 3 terms: AW=3 DW=4
    logic s_we = 1'b0; logic [2:0] s_addr = '0; logic [3:0]  s_data = '0; logic [1:0] s_out;
    // read-only 2x2: AW=3 DW=4
    logic t_we = 1'b0; logic [2:0] t_addr = '0; logic [3:0]  t_data = '0; logic [1:0] t_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  sh_and [8];
    logic [7:0]  sh_or  [4];
    logic [7:0]  pa_and [8];
    logic [7:0]  pa_or  [4];
    logic [7:0]  pa_own [4];
    logic [15:0] ro_col [4];

    always #5 clk = ~clk;

    sop_logic_array #(.MODE(SOP_PLA), .N_IN(4), .M_OUT(4), .P_TERMS(8)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(p_we), .cfg_addr(p_addr), .cfg_data(p_data),
        .in_vec(vin), .out_vec(p_out));
    sop_logic_array #(.MODE(SOP_ROM), .N_IN(4), .M_OUT(4), .P_TERMS(8)) dut_rom (
        .clk(clk), .rst_n(rst_n), .cfg_we(r_we), .cfg_addr(r_addr), .cfg_data(r_data),
        .in_vec(vin), .out_vec(r_out));
    sop_logic_array #(.MODE(SOP_PAL), .N_IN(4), .M_OUT(4), .P_TERMS(8)) dut_pal (
        .clk(clk), .rst_n(rst_n), .cfg_we(f_we), .cfg_addr(f_addr), .cfg_data(f_data),
        .in_vec(vin), .out_vec(f_out));
    sop_logic_array #(.MODE(SOP_PLA), .N_IN(2), .M_OUT(2), .P_TERMS(3)) dut_s2p (
        .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_addr(s_addr), .cfg_data(s_data),
        .in_vec(vin[1:0]), .out_vec(s_out));
    sop_logic_array #(.MODE(SOP_ROM), .N_IN(2), .M_OUT(2), .P_TERMS(3)) dut_s2r (
        .clk(clk), .rst_n(rst_n), .cfg_we(t_we), .cfg_addr(t_addr), .cfg_data(t_data),
        .in_vec(vin[1:0]), .out_vec(t_out));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (vin=%h)", req, act, exp, vin);
        end
    endtask

    // Sum-of-products reference from bench shadow copies
    function automatic logic [3:0] model(input bit fixed_or, input logic [3:0] x);
        logic [3:0] o;
        logic [7:0] tv;
        logic [7:0] row;
        o = '0;
        for (int t = 0; t < 8; t++) begin
            row = fixed_or ? pa_and[t] : sh_and[t];
            tv[t] = 1'b1;
            for (int i = 0; i < 4; i++) begin
                if (row[2*i]   && !x[i]) tv[t] = 1'b0;
                if (row[2*i+1] &&  x[i]) tv[t] = 1'b0;
            end
        end
        for (int k = 0; k < 4; k++) o[k] = |((fixed_or ? pa_or[k] : sh_or[k]) & tv);
        return o;
    endfunction

    task automatic cfg_wr(input int which, input int a, input logic [15:0] d);
        @(negedge clk);
        case (which)
            0: begin p_we = 1'b1; p_addr = 4'(a); p_data = d[7:0]; end
            1: begin r_we = 1'b1; r_addr = 5'(a); r_data = d;      end
            2: begin f_we = 1'b1; f_addr = 4'(a); f_data = d[7:0]; end
            3: begin s_we = 1'b1; s_addr = 3'(a); s_data = d[3:0]; end
            default: begin t_we = 1'b1; t_addr = 3'(a); t_data = d[3:0]; end
        endcase
        @(negedge clk);
        p_we = 1'b0; r_we = 1'b0; f_we = 1'b0; s_we = 1'b0; t_we = 1'b0;
    endtask

    task automatic pla_wr(input int a, input logic [7:0] d);
        cfg_wr(0, a, {8'h00, d});
        if (a < 8) sh_and[a] = d;
        else if (a < 12) sh_or[a-8] = d;
    endtask

    task automatic pal_wr(input int a, input logic [7:0] d);
        cfg_wr(2, a, {8'h00, d});
        if (a < 8) pa_and[a] = d;
        else if (a < 12) pa_or[a-8] = d & pa_own[a-8];
    endtask

    task automatic apply(input logic [3:0] x);
        @(negedge clk);
        vin = x;
        #1;
    endtask

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d8;
        logic [15:0] d16;
        int a;
        void'($urandom(32'd2024));
        for (int t = 0; t < 8; t++) begin sh_and[t] = '0; pa_and[t] = '0; end
        for (int k = 0; k < 4; k++) begin sh_or[k] = '0; pa_or[k] = '0; ro_col[k] = '0; end
        // R7 group layout: out0 terms 0-2, out1 3-4, out2 5-6, out3 7
        pa_own[0] = 8'b0000_0111; pa_own[1] = 8'b0001_1000;
        pa_own[2] = 8'b0110_0000; pa_own[3] = 8'b1000_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything low after reset
        for (int x = 0; x < 16; x++) begin
            apply(4'(x));
            chk("R1 pla", {12'h0, p_out}, 16'h0);
            chk("R1 rom", {12'h0, r_out}, 16'h0);
            chk("R1 pal", {12'h0, f_out}, 16'h0);
        end

        // R3 empty row -> 1 on out0; both literals of input2 -> 0 on out1
        pla_wr(0, 8'h00);
        pla_wr(8, 8'h01);
        pla_wr(1, 8'h30);
        pla_wr(9, 8'h02);
        // R2 in0 true and in3 complement: bits 0 and 7
        pla_wr(2, 8'h81);
        pla_wr(10, 8'h04);
        // R5 term 2 also feeds out3 alongside term 1
        pla_wr(11, 8'h06);
        for (int x = 0; x < 16; x++) begin
            apply(4'(x));
            chk("R3 empty term", {15'h0, p_out[0]}, 16'h1);
            chk("R3 contradictory term", {15'h0, p_out[1]}, 16'h0);
            chk("R2 literal pair", {15'h0, p_out[2]}, {15'h0, (x[0] & ~x[3])});
            chk("R5 shared term", {15'h0, p_out[3]}, {15'h0, (x[0] & ~x[3])});
        end

        // R4 clearing a column drives its output to 0
        pla_wr(8, 8'h00);
        apply(4'h5);
        chk("R4 empty column", {15'h0, p_out[0]}, 16'h0);

        // R9 out-of-range column index ignored
        pla_wr(13, 8'hFF);
        for (int x = 0; x < 16; x++) begin
            apply(4'(x));
            chk("R9 out-of-range write", {12'h0, p_out}, {12'h0, model(1'b0, 4'(x))});
        end

        // R10 combinational response mid-cycle, no clock edge in between
        @(posedge clk); #2;
        vin = 4'b0001; #1;
        chk("R10 comb rise", {15'h0, p_out[2]}, 16'h1);
        vin = 4'b1001; #1;
        chk("R10 comb fall", {15'h0, p_out[2]}, 16'h0);

        // R4 random programmable traffic against the model
        for (int r = 0; r < 60; r++) begin
            a = $urandom_range(0, 15);
            d8 = 8'($urandom);
            pla_wr(a, d8);
            for (int q = 0; q < 4; q++) begin
                apply(4'($urandom));
                chk("R4 random pla", {12'h0, p_out}, {12'h0, model(1'b0, vin)});
            end
        end

        // R6 truth tables in the read-only build
        for (int k = 0; k < 4; k++) begin
            d16 = 16'($urandom);
            ro_col[k] = d16;
            cfg_wr(1, 16 + k, d16);
        end
        // R6 AND-plane writes have no effect
        cfg_wr(1, 3, 16'hFFFF);
        cfg_wr(1, 0, 16'h0000);
        for (int x = 0; x < 16; x++) begin
            apply(4'(x));
            for (int k = 0; k < 4; k++)
                chk("R6 rom table", {15'h0, r_out[k]}, {15'h0, ro_col[k][x]});
        end

        // R8 out3 owns only term 7: term 6 (in1) cannot join it
        pal_wr(7, 8'h01);
        pal_wr(6, 8'h04);
        pal_wr(11, 8'hC0);
        apply(4'b0010);
        chk("R8 term budget", {15'h0, f_out[3]}, 16'h0);
        apply(4'b0001);
        chk("R8 owned term", {15'h0, f_out[3]}, 16'h1);

        // R7 all-ones columns are clipped to each output's group
        for (int r = 0; r < 30; r++) begin
            a = $urandom_range(0, 11);
            d8 = (a >= 8) ? 8'hFF : 8'($urandom);
            pal_wr(a, d8);
            for (int q = 0; q < 3; q++) begin
                apply(4'($urandom));
                chk("R7 pal groups", {12'h0, f_out}, {12'h0, model(1'b1, vin)});
            end
        end

        // R11 two-input self-test, programmable: i1i0, i1i0', i1'i0'
        cfg_wr(3, 0, 16'h5);
        cfg_wr(3, 1, 16'h6);
        cfg_wr(3, 2, 16'hA);
        cfg_wr(3, 4, 16'h3);
        cfg_wr(3, 5, 16'h5);
        // R11 read-only: out0 true at 2,3; out1 true at 0,3
        cfg_wr(4, 4, 16'hC);
        cfg_wr(4, 5, 16'h9);
        for (int x = 0; x < 4; x++) begin
            apply(4'(x));
            chk("R11 pla", {14'h0, s_out}, {14'h0, ~(x[1] ^ x[0]), x[1]});
            chk("R11 rom", {14'h0, t_out}, {14'h0, ~(x[1] ^ x[0]), x[1]});
        end

        // R1 a later reset clears configured planes
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int x = 0; x < 16; x++) begin
            apply(4'(x));
            chk("R1 re-reset pla", {12'h0, p_out}, 16'h0);
            chk("R1 re-reset rom", {12'h0, r_out}, 16'h0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule